// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a single 32-pin general-purpose I/O bank controlled through a simple 32-bit register bus. Each pin has an output value and a direction bit. The direction bit drives the pad output enable. The output value can only be changed through write-only set and clear aliases. Direction and the two edge-enable registers have the same kind of aliases next to their directly writable copies. Firmware can therefore change individual bits without a read-modify-write sequence.

Pad inputs pass through a two-flop synchroniser. The synchronised value can be read back and is compared with its value from the previous cycle to find rising and falling edges. An edge on a pin whose matching enable is set is latched in a write-one-to-clear status register. The status is combined with two independent mask registers to form two interrupt outputs. A parameter chooses between a wide register layout with a 12-byte stride and a compact layout with a 4-byte stride.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, direction, output value, both edge enables, both masks and edge status are all zero, and `irq` and `irq_alt` are low.
- R2: A write to the direction register loads it. The register reads back, and `pad_oe` follows it; a 1 bit means the pin is an output.
- R3: Writing to the output-set alias (index 2) sets every `pad_out` bit written as 1. Writing to the output-clear alias (index 3) clears every `pad_out` bit written as 1. Bits written as 0, and all other accesses, leave `pad_out` unchanged.
- R4: Direction (set at index 7, clear at index 8), rising enable (set 9, clear 10) and falling enable (set 11, clear 12) each have aliases. Writing 1 to a bit of a set alias sets that bit, writing 1 to a bit of a clear alias clears it, and 0 bits have no effect.
- R5: The level register (index 0) returns the pad input delayed by two clock edges, whatever the direction setting.
- R6: A rising edge on a pin with its rising enable set, or a falling edge on a pin with its falling enable set, sets that pin's status bit (index 6) in the third clock edge after the pad change. An edge whose enable is clear sets nothing.
- R7: Writing 1 to a status bit clears it, and 0 bits are untouched. A read of the status returns every latched edge, masked or not.
- R8: When a new enabled edge on a pin and a write-one-to-clear of that pin's status bit happen in the same cycle, the status bit remains set.
- R9: `irq` is high exactly when status AND mask (index 13) is nonzero. `irq_alt` is high exactly when status AND the second mask (index 14) is nonzero. In both masks, 1 enables a pin.
- R10: Reads of write-only alias addresses return zero. Writes to unmapped offsets change nothing, and reads of unmapped offsets return zero.
- R11: The byte offset of register index k is 12*k in the wide layout (default, mask at 0x9C, second mask at 0xA8) and 4*k in the compact layout (mask at 0x34, second mask at 0x38). Any other offset is unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read access |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Output value to pads |
| pad_oe | output | 32 | Output enable per pin (direction register) |
| irq | output | 1 | Bank interrupt through the main mask |
| irq_alt | output | 1 | Bank interrupt through the second mask |

## Verification
The assertions assume that bus accesses are single-cycle strobes whose address, write flag and data are stable around the sampling edge. They also assume that reset is applied asynchronously before the first access. The bench changes bus signals and pad inputs only on falling clock edges, so every strobe is sampled cleanly. The pad inputs may change freely, because the synchroniser takes them in. Only port-level behaviour is asserted, which leaves the metastable first stage unconstrained. The stimulus holds each pad value for at least three edges so that every edge reaches the status register.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NREG = 15;

    // Register indices; the offset of index k is k times the layout stride.
    typedef enum logic [3:0] {
        RG_LEVEL    = 4'd0,
        RG_DIR      = 4'd1,
        RG_OUT_SET  = 4'd2,
        RG_OUT_CLR  = 4'd3,
        RG_RISE_EN  = 4'd4,
        RG_FALL_EN  = 4'd5,
        RG_STATUS   = 4'd6,
        RG_DIR_SET  = 4'd7,
        RG_DIR_CLR  = 4'd8,
        RG_RISE_SET = 4'd9,
        RG_RISE_CLR = 4'd10,
        RG_FALL_SET = 4'd11,
        RG_FALL_CLR = 4'd12,
        RG_MASK     = 4'd13,
        RG_MASK2    = 4'd14
    } reg_idx_e;

    function automatic int unsigned reg_stride(input bit compact);
        return compact ? 4 : 12;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int AW      = 8,
    parameter bit COMPACT = 1'b0
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output reg_idx_e      idx
);
    localparam int STRIDE = int'(reg_stride(COMPACT));

    logic [NREG-1:0] match;

    for (genvar i = 0; i < NREG; i++) begin : g_match
        assign match[i] = (addr == AW'(i * STRIDE));
    end

    always_comb begin
        hit = |match;
        idx = RG_LEVEL;
        for (int i = 0; i < NREG; i++) begin
            if (match[i]) idx = reg_idx_e'(4'(i));
        end
    end
endmodule

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [W-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pad_in;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level = s_q.sync;
    assign rise  = s_q.sync & ~s_q.prev;
    assign fall  = ~s_q.sync & s_q.prev;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int PINS        = 32,
    parameter int AW          = 8,
    parameter bit COMPACT_MAP = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [PINS-1:0] bus_wdata,
    output logic [PINS-1:0] bus_rdata,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic            irq,
    output logic            irq_alt
);
    typedef struct packed {
        logic [PINS-1:0] dir;
        logic [PINS-1:0] dout;
        logic [PINS-1:0] rise_en;
        logic [PINS-1:0] fall_en;
        logic [PINS-1:0] status;
        logic [PINS-1:0] mask;
        logic [PINS-1:0] mask2;
    } bank_t;

    bank_t st_d, st_q;

    logic            hit;
    reg_idx_e        idx;
    logic [PINS-1:0] level, rise, fall;
    logic            wr, rd;
    logic [PINS-1:0] w1c, ev;

    gpio_addr_dec #(.AW(AW), .COMPACT(COMPACT_MAP)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx)
    );

    gpio_sync_edge #(.W(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .level  (level),
        .rise   (rise),
        .fall   (fall)
    );

    assign wr  = bus_en && bus_we && hit;
    assign rd  = bus_en && !bus_we && hit;
    assign w1c = (wr && idx == RG_STATUS) ? bus_wdata : '0;
    assign ev  = (rise & st_q.rise_en) | (fall & st_q.fall_en);

    always_comb begin
        st_d        = st_q;
        // clear first, then set, so a coincident new edge survives
        st_d.status = (st_q.status & ~w1c) | ev;
        if (wr) begin
            unique case (idx)
                RG_DIR:      st_d.dir     = bus_wdata;
                RG_OUT_SET:  st_d.dout    = st_q.dout | bus_wdata;
                RG_OUT_CLR:  st_d.dout    = st_q.dout & ~bus_wdata;
                RG_RISE_EN:  st_d.rise_en = bus_wdata;
                RG_FALL_EN:  st_d.fall_en = bus_wdata;
                RG_DIR_SET:  st_d.dir     = st_q.dir | bus_wdata;
                RG_DIR_CLR:  st_d.dir     = st_q.dir & ~bus_wdata;
                RG_RISE_SET: st_d.rise_en = st_q.rise_en | bus_wdata;
                RG_RISE_CLR: st_d.rise_en = st_q.rise_en & ~bus_wdata;
                RG_FALL_SET: st_d.fall_en = st_q.fall_en | bus_wdata;
                RG_FALL_CLR: st_d.fall_en = st_q.fall_en & ~bus_wdata;
                RG_MASK:     st_d.mask    = bus_wdata;
                RG_MASK2:    st_d.mask2   = bus_wdata;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            unique case (idx)
                RG_LEVEL:   bus_rdata = level;
                RG_DIR:     bus_rdata = st_q.dir;
                RG_RISE_EN: bus_rdata = st_q.rise_en;
                RG_FALL_EN: bus_rdata = st_q.fall_en;
                RG_STATUS:  bus_rdata = st_q.status;
                RG_MASK:    bus_rdata = st_q.mask;
                RG_MASK2:   bus_rdata = st_q.mask2;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign pad_out = st_q.dout;
    assign pad_oe  = st_q.dir;
    assign irq     = |(st_q.status & st_q.mask);
    assign irq_alt = |(st_q.status & st_q.mask2);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int PINS        = 32,
    parameter int AW          = 8,
    parameter bit COMPACT_MAP = 1'b0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_en,
    input logic            bus_we,
    input logic [AW-1:0]   bus_addr,
    input logic [PINS-1:0] bus_wdata,
    input logic [PINS-1:0] bus_rdata,
    input logic [PINS-1:0] pad_out,
    input logic [PINS-1:0] pad_oe,
    input logic            irq,
    input logic [PINS-1:0] mask_q
);
    localparam int STRIDE = int'(reg_stride(COMPACT_MAP));
    localparam logic [AW-1:0] A_DIR     = AW'(int'(RG_DIR) * STRIDE);
    localparam logic [AW-1:0] A_OUT_SET = AW'(int'(RG_OUT_SET) * STRIDE);
    localparam logic [AW-1:0] A_OUT_CLR = AW'(int'(RG_OUT_CLR) * STRIDE);
    localparam logic [AW-1:0] A_DIR_CLR = AW'(int'(RG_DIR_CLR) * STRIDE);

    logic wr;
    assign wr = bus_en && bus_we;

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_DIR) |=> (pad_oe == $past(bus_wdata)));

    // R3
    out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_OUT_SET) |=> (pad_out == ($past(pad_out) | $past(bus_wdata))));

    // R3
    out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_OUT_CLR) |=> (pad_out == ($past(pad_out) & ~$past(bus_wdata))));

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (bus_addr == A_OUT_SET || bus_addr == A_OUT_CLR)) |=> $stable(pad_out));

    // R4
    dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_DIR_CLR) |=> (pad_oe == ($past(pad_oe) & ~$past(bus_wdata))));

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    // R10
    alias_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && (bus_addr == A_OUT_SET || bus_addr == A_OUT_CLR)) |-> (bus_rdata == '0));
endmodule

bind gpio_edge_bank gpio_bank_chk #(
    .PINS(PINS), .AW(AW), .COMPACT_MAP(COMPACT_MAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .mask_q    (st_q.mask)
);

// File: tb/sim_gpio_edge_bank.sv
`timescale 1ns/1ps
module sim_gpio_edge_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  addr_w = '0, addr_c = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pad_in = '0;
    logic [31:0] rdata_w, rdata_c, pout_w, pout_c, poe_w, poe_c;
    logic        irq_w, irq_c, irqa_w, irqa_c;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_edge_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(addr_w), .bus_wdata(bus_wdata), .bus_rdata(rdata_w),
        .pad_in(pad_in), .pad_out(pout_w), .pad_oe(poe_w),
        .irq(irq_w), .irq_alt(irqa_w)
    );

    gpio_edge_bank #(.COMPACT_MAP(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(addr_c), .bus_wdata(bus_wdata), .bus_rdata(rdata_c),
        .pad_in(pad_in), .pad_out(pout_c), .pad_oe(poe_c),
        .irq(irq_c), .irq_alt(irqa_c)
    );

    // register indices used by the bench
    localparam int I_LEVEL = 0, I_DIR = 1, I_OSET = 2, I_OCLR = 3, I_RISE = 4,
                   I_FALL = 5, I_STAT = 6, I_DSET = 7, I_DCLR = 8, I_RSET = 9,
                   I_RCLR = 10, I_FSET = 11, I_FCLR = 12, I_MASK = 13, I_MASK2 = 14;

    typedef struct packed {
        logic        wr;
        logic [3:0]  idx;
        logic [31:0] data;   // write data, or expected read value
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd1,  32'h0000_00FF, 4'd2},  // R2 direct direction write
        '{1'b0, 4'd1,  32'h0000_00FF, 4'd2},  // R2
        '{1'b1, 4'd7,  32'h0000_0F00, 4'd4},  // R4 direction set
        '{1'b0, 4'd1,  32'h0000_0FFF, 4'd4},  // R4
        '{1'b1, 4'd8,  32'h0000_000F, 4'd4},  // R4 direction clear
        '{1'b0, 4'd1,  32'h0000_0FF0, 4'd4},  // R4
        '{1'b1, 4'd9,  32'h0000_00A5, 4'd4},  // R4 rising set
        '{1'b0, 4'd4,  32'h0000_00A5, 4'd4},  // R4
        '{1'b1, 4'd10, 32'h0000_0005, 4'd4},  // R4 rising clear
        '{1'b0, 4'd4,  32'h0000_00A0, 4'd4},  // R4
        '{1'b1, 4'd11, 32'h0000_003C, 4'd4},  // R4 falling set
        '{1'b1, 4'd12, 32'h0000_000C, 4'd4},  // R4 falling clear
        '{1'b0, 4'd5,  32'h0000_0030, 4'd4},  // R4
        '{1'b1, 4'd2,  32'h0000_F0F0, 4'd3},  // R3 output set
        '{1'b0, 4'd2,  32'h0000_0000, 4'd10}, // R10 alias reads zero
        '{1'b1, 4'd3,  32'h0000_00F0, 4'd3},  // R3 output clear
        '{1'b1, 4'd13, 32'h1234_5678, 4'd9},  // R9 mask
        '{1'b0, 4'd13, 32'h1234_5678, 4'd9},  // R9
        '{1'b1, 4'd14, 32'hFFFF_0000, 4'd11}, // R11 second mask at top offset
        '{1'b0, 4'd14, 32'hFFFF_0000, 4'd11}  // R11
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_raw(input logic [7:0] aw, input logic [7:0] ac, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; addr_w = aw; addr_c = ac; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        wr_raw(8'(idx * 12), 8'(idx * 4), d);
    endtask

    task automatic rd_raw(input logic [7:0] aw, input logic [7:0] ac,
                          output logic [31:0] rw, output logic [31:0] rc);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; addr_w = aw; addr_c = ac;
        #1;
        rw = rdata_w; rc = rdata_c;
        bus_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int idx, input logic [31:0] exp);
        logic [31:0] rw, rc;
        rd_raw(8'(idx * 12), 8'(idx * 4), rw, rc);
        check({tag, " wide"}, rw, exp);
        check({tag, " compact"}, rc, exp);
    endtask

    task automatic pad_step(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic irq_chk(input string tag, input logic e, input logic ea);
        check({tag, " irq wide"}, 32'(irq_w), 32'(e));
        check({tag, " irq compact"}, 32'(irq_c), 32'(e));
        check({tag, " irq_alt wide"}, 32'(irqa_w), 32'(ea));
        check({tag, " irq_alt compact"}, 32'(irqa_c), 32'(ea));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rw, rc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 dir", I_DIR, 32'h0);
        rd_chk("R1 rise_en", I_RISE, 32'h0);
        rd_chk("R1 fall_en", I_FALL, 32'h0);
        rd_chk("R1 status", I_STAT, 32'h0);
        rd_chk("R1 mask", I_MASK, 32'h0);
        rd_chk("R1 mask2", I_MASK2, 32'h0);
        check("R1 pad_out", pout_w | pout_c, 32'h0);
        check("R1 pad_oe", poe_w | poe_c, 32'h0);
        irq_chk("R1", 1'b0, 1'b0);

        // register vectors
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(int'(VEC[i].idx), VEC[i].data);
            else rd_chk($sformatf("R%0d table[%0d]", VEC[i].req, i), int'(VEC[i].idx), VEC[i].data);
        end
        check("R2 pad_oe wide", poe_w, 32'h0000_0FF0);
        check("R2 pad_oe compact", poe_c, 32'h0000_0FF0);
        check("R3 pad_out wide", pout_w, 32'h0000_F000);
        check("R3 pad_out compact", pout_c, 32'h0000_F000);

        wr(I_RISE, 32'h0); wr(I_FALL, 32'h0); wr(I_MASK, 32'h0); wr(I_MASK2, 32'h0);

        // R5 level: all pins outputs, value appears after two edges
        wr(I_DIR, 32'hFFFF_FFFF);
        @(negedge clk);
        pad_in = 32'hDEAD_BEEF;
        bus_en = 1'b1; bus_we = 1'b0; addr_w = 8'(I_LEVEL * 12); addr_c = 8'(I_LEVEL * 4);
        @(posedge clk); #1;
        check("R5 level after one edge wide", rdata_w, 32'h0);
        check("R5 level after one edge compact", rdata_c, 32'h0);
        @(posedge clk); #1;
        check("R5 level after two edges wide", rdata_w, 32'hDEAD_BEEF);
        check("R5 level after two edges compact", rdata_c, 32'hDEAD_BEEF);
        bus_en = 1'b0;

        // R6 edges with enables clear latch nothing
        pad_step(32'h0);
        rd_chk("R6 disabled edges", I_STAT, 32'h0);

        // R6 enabled edges
        wr(I_RISE, 32'h1); wr(I_FALL, 32'h2);
        pad_step(32'h1);
        rd_chk("R6 rise bit0", I_STAT, 32'h1);
        pad_step(32'h3);
        rd_chk("R6 rise bit1 not enabled", I_STAT, 32'h1);
        pad_step(32'h1);
        rd_chk("R6 fall bit1", I_STAT, 32'h3);
        pad_step(32'h0);
        rd_chk("R6 fall bit0 not enabled", I_STAT, 32'h3);
        irq_chk("R9 masks zero", 1'b0, 1'b0);

        // R9 masks
        wr(I_MASK, 32'h2);
        wr(I_MASK2, 32'h1);
        irq_chk("R9 both masked in", 1'b1, 1'b1);

        // R7 write-one-to-clear
        wr(I_STAT, 32'h2);
        rd_chk("R7 clear bit1", I_STAT, 32'h1);
        irq_chk("R9 after clear", 1'b0, 1'b1);
        wr(I_STAT, 32'h0);
        rd_chk("R7 zero write and unmasked read", I_STAT, 32'h1);

        // R8 edge coincides with clear of the same bit
        @(negedge clk);
        pad_in = 32'h1;
        @(negedge clk);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; addr_w = 8'(I_STAT * 12); addr_c = 8'(I_STAT * 4);
        bus_wdata = 32'h1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        rd_chk("R8 edge wins over clear", I_STAT, 32'h1);
        wr(I_STAT, 32'h1);
        rd_chk("R7 plain clear", I_STAT, 32'h0);
        irq_chk("R9 status empty", 1'b0, 1'b0);

        // R10 unmapped accesses
        wr_raw(8'h01, 8'h01, 32'hFFFF_FFFF);
        rd_chk("R10 mask after unmapped write", I_MASK, 32'h2);
        rd_raw(8'h01, 8'h01, rw, rc);
        check("R10 unmapped read wide", rw, 32'h0);
        check("R10 unmapped read compact", rc, 32'h0);
        rd_raw(8'hFC, 8'hFC, rw, rc);
        check("R10 high unmapped read wide", rw, 32'h0);
        check("R10 high unmapped read compact", rc, 32'h0);

        // R11 offset 0x04 is direction only in the compact layout
        wr(I_DIR, 32'h0);
        wr_raw(8'h04, 8'h04, 32'h55);
        check("R11 wide ignores 0x04", poe_w, 32'h0);
        check("R11 compact dir at 0x04", poe_c, 32'h55);
        rd_raw(8'hA8, 8'h38, rw, rc);
        check("R11 second mask wide 0xA8", rw, 32'h1);
        check("R11 second mask compact 0x38", rc, 32'h1);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule